// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets logic running on a single clock read and write an external static RAM that has no clock of its own. The default geometry is 131,072 words of 8 bits. The memory has two chip selects of opposite polarity, an active-low write strobe, an active-low output enable and one shared bidirectional data bus. The host side uses a simple handshake. While `host_ready` is high, a request is taken on the clock edge where `host_req` is high. The direction, address and write data are captured on that edge. The controller then plays out the memory cycle and answers with a one-cycle `host_done` pulse. For a read, the byte is on `host_rdata` when the pulse arrives.

Every memory timing minimum is a parameter counted in clock periods. The integrator takes the nanosecond figure of the fitted memory, divides it by the clock period and rounds up. The four parameters are:
- address-to-strobe setup;
- write-strobe width;
- read access window;
- bus turnaround after a read.

Writes are controlled by the write strobe, and the output enable stays high throughout. When the controller is idle, it leaves the memory deselected, with all strobes inactive and the data bus released, so the memory sits in its low-power standby.

Top module: `asram_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after, the pins are `mem_ce_n`=1, `mem_ce`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0. `host_ready`=1 and `host_done`=0.
- R2: The memory is selected (`mem_ce_n`=0 and `mem_ce`=1) only during the setup, strobe and write-hold phases of an access. In every other cycle both selects are inactive. `host_ready` is high only in idle cycles, and in those cycles all strobes are inactive and the bus is released.
- R3: A request is accepted when `host_req` and `host_ready` are both high at a clock edge. `mem_addr` carries the captured address from the next cycle on and does not change while the memory stays selected. A request raised while `host_ready` is low has no effect on the pins or on the sequence.
- R4: A write accepted at edge k proceeds as follows:
  - SETUP_CYC cycles: selected, `mem_we_n`=1, `mem_oe_n`=1.
  - WR_PULSE_CYC cycles: `mem_we_n`=0, `mem_oe_n`=1.
  - One hold cycle: `mem_we_n`=1, still selected.

  The captured data is on `mem_dq_out` with `mem_dq_oe`=1 in all of these cycles.
- R5: A write completes by returning to idle. In the idle cycle k+SETUP_CYC+WR_PULSE_CYC+2, `host_done`=1 and `host_ready`=1.
- R6: A read accepted at edge k holds the memory selected with `mem_oe_n`=1 for SETUP_CYC cycles. It then drives `mem_oe_n`=0 for RD_ACCESS_CYC cycles. `mem_we_n` stays 1 and `mem_dq_oe` stays 0 throughout the read.
- R7: Read data is sampled from `mem_dq_in` at the edge that ends the last `mem_oe_n`=0 cycle. It appears on `host_rdata` with `host_done`=1 in cycle k+SETUP_CYC+RD_ACCESS_CYC+1, and `host_rdata` keeps that value until the next read completes.
- R8: After each read, the controller spends TURN_CYC cycles deselected with `mem_dq_oe`=0 and `host_ready`=0. `host_ready` rises in cycle k+SETUP_CYC+RD_ACCESS_CYC+TURN_CYC+1. `mem_dq_oe` rises only from a cycle in which the memory was deselected and `mem_oe_n` was 1.
- R9: `mem_we_n` and `mem_oe_n` are never low in the same cycle, and `mem_dq_oe` is never high while `mem_oe_n` is low.
- R10: A request held high while the controller is busy is accepted in the first cycle that `host_ready` is high, and `host_ready` drops in the next cycle.
- R11: `host_done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_ready | output | 1 | Controller idle, request can be taken |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Last read data |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | DATA_W | Data from the memory |

## Verification
For an acceptance at edge k, each result has a fixed due cycle:
- A write's done pulse and renewed ready fall in cycle k+SETUP_CYC+WR_PULSE_CYC+2.
- A read's done pulse and data fall in cycle k+SETUP_CYC+RD_ACCESS_CYC+1.
- A read's ready returns in cycle k+SETUP_CYC+RD_ACCESS_CYC+TURN_CYC+1.

On acceptance, the bench expands every request into a per-cycle queue of expected pin and handshake values. It pops one entry at each falling edge and compares, so every output is checked in exactly the cycle it is due.

The memory model drives a poison byte on the bus until the output enable has been low for the whole access window. A sample taken one cycle early therefore returns a wrong value. While the controller is busy, random requests are applied to confirm that they are ignored.

// File: rtl/asram_pkg.sv
package asram_pkg;

  // Phases of one memory access.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_HOLD,
    ST_TURN
  } asram_state_t;

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int SETUP_CYC     = 1,
  parameter int WR_PULSE_CYC  = 4,
  parameter int RD_ACCESS_CYC = 6,
  parameter int TURN_CYC      = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req,
  input  logic         req_wr,
  output asram_state_t state,
  output asram_state_t nxt,
  output logic         op_wr_nxt,
  output logic         accept,
  output logic         sample,
  output logic         wr_end
);

  localparam int MAX_AB = (SETUP_CYC > WR_PULSE_CYC) ? SETUP_CYC : WR_PULSE_CYC;
  localparam int MAX_CD = (RD_ACCESS_CYC > TURN_CYC) ? RD_ACCESS_CYC : TURN_CYC;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAXC + 1);

  logic             op_wr;
  logic             ld;
  logic [CNT_W-1:0] ldv;
  logic             expired;

  asram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ldv),
    .expired  (expired)
  );

  always_comb begin
    nxt = state;
    ld  = 1'b0;
    ldv = '0;
    unique case (state)
      ST_IDLE: begin
        if (req) begin
          nxt = ST_SETUP;
          ld  = 1'b1;
          ldv = CNT_W'(SETUP_CYC - 1);
        end
      end
      ST_SETUP: begin
        if (expired) begin
          nxt = ST_ACCESS;
          ld  = 1'b1;
          ldv = op_wr ? CNT_W'(WR_PULSE_CYC - 1) : CNT_W'(RD_ACCESS_CYC - 1);
        end
      end
      ST_ACCESS: begin
        if (expired) begin
          if (op_wr) begin
            nxt = ST_HOLD;
          end else begin
            nxt = ST_TURN;
            ld  = 1'b1;
            ldv = CNT_W'(TURN_CYC - 1);
          end
        end
      end
      ST_HOLD: nxt = ST_IDLE;
      ST_TURN: begin
        if (expired) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign accept    = (state == ST_IDLE) && req;
  assign op_wr_nxt = accept ? req_wr : op_wr;
  assign sample    = (state == ST_ACCESS) && expired && !op_wr;
  assign wr_end    = (state == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      op_wr <= 1'b0;
    end else begin
      state <= nxt;
      op_wr <= op_wr_nxt;
    end
  end

  // R4
  hold_single_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD) |=> (state == ST_IDLE));

  // R8
  turn_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TURN) |-> !op_wr);

endmodule

// File: rtl/asram_io.sv
module asram_io
  import asram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  asram_state_t      nxt,
  input  logic              op_wr_nxt,
  input  logic              accept,
  input  logic              sample,
  input  logic              wr_end,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_done
);

  logic sel_nxt;
  logic strobe_nxt;

  assign sel_nxt    = (nxt == ST_SETUP) || (nxt == ST_ACCESS) || (nxt == ST_HOLD);
  assign strobe_nxt = (nxt == ST_ACCESS);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ce_n   <= 1'b1;
      mem_ce     <= 1'b0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      host_done  <= 1'b0;
      host_rdata <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else begin
      mem_ce_n  <= !sel_nxt;
      mem_ce    <= sel_nxt;
      mem_we_n  <= !(strobe_nxt && op_wr_nxt);
      mem_oe_n  <= !(strobe_nxt && !op_wr_nxt);
      mem_dq_oe <= sel_nxt && op_wr_nxt;
      host_done <= sample || wr_end;
      if (sample) host_rdata <= mem_dq_in;
      if (accept) begin
        mem_addr   <= host_addr;
        mem_dq_out <= host_wdata;
      end
    end
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!mem_we_n && !mem_oe_n));

  // R4
  we_selected_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_ce && mem_oe_n && mem_dq_oe));

  // R6
  oe_selected_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_ce && !mem_dq_oe));

  // R8
  drive_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> ($past(mem_ce_n) && $past(mem_oe_n)));

  // R3
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    host_done |=> !host_done);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int SETUP_CYC     = 1,
  parameter int WR_PULSE_CYC  = 4,
  parameter int RD_ACCESS_CYC = 6,
  parameter int TURN_CYC      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic              host_done,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  asram_state_t state;
  asram_state_t nxt;
  logic         op_wr_nxt;
  logic         accept;
  logic         sample;
  logic         wr_end;

  asram_seq #(
    .SETUP_CYC     (SETUP_CYC),
    .WR_PULSE_CYC  (WR_PULSE_CYC),
    .RD_ACCESS_CYC (RD_ACCESS_CYC),
    .TURN_CYC      (TURN_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req       (host_req),
    .req_wr    (host_wr),
    .state     (state),
    .nxt       (nxt),
    .op_wr_nxt (op_wr_nxt),
    .accept    (accept),
    .sample    (sample),
    .wr_end    (wr_end)
  );

  asram_io #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_io (
    .clk        (clk),
    .rst        (rst),
    .nxt        (nxt),
    .op_wr_nxt  (op_wr_nxt),
    .accept     (accept),
    .sample     (sample),
    .wr_end     (wr_end),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_ce     (mem_ce),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .host_rdata (host_rdata),
    .host_done  (host_done)
  );

  assign host_ready = (state == ST_IDLE);

  // R2
  idle_parked_chk: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> (mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe));

  // R10
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (host_req && host_ready) |=> !host_ready);

endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

  localparam int AW = 17;
  localparam int DW = 8;
  localparam int SC = 1;
  localparam int WP = 4;
  localparam int RA = 6;
  localparam int TT = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic          host_req, host_wr;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_wdata;
  logic          host_ready, host_done;
  logic [DW-1:0] host_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out, mem_dq_in;

  asram_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SC),
    .WR_PULSE_CYC(WP), .RD_ACCESS_CYC(RA), .TURN_CYC(TT)
  ) u_dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_done(host_done), .host_rdata(host_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // ---------------- memory model ----------------
  logic [DW-1:0] mem_store [int];
  int oe_cnt = 0;

  function automatic logic [DW-1:0] mem_peek(logic [AW-1:0] a);
    if (mem_store.exists(int'(a))) return mem_store[int'(a)];
    return '0;
  endfunction

  always @(posedge clk) begin
    if (mem_oe_n) oe_cnt <= 0;
    else          oe_cnt <= oe_cnt + 1;
  end

  always @(posedge mem_we_n) begin
    if (!mem_ce_n && mem_ce && mem_dq_oe) mem_store[int'(mem_addr)] = mem_dq_out;
  end

  assign mem_dq_in = (!mem_ce_n && mem_ce && mem_we_n && !mem_oe_n && oe_cnt >= RA - 1)
                     ? mem_peek(mem_addr) : 8'hEE;

  // ---------------- reference schedule ----------------
  typedef struct packed {
    logic          ce_n, ce, we_n, oe_n, dq_oe, ready, done;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          chk_rd;
    logic [DW-1:0] rdv;
  } exp_t;

  typedef struct {
    bit            wr;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int            gap;
  } op_t;

  exp_t q[$];
  op_t  ops[$];
  logic [DW-1:0] shadow [int];
  int n_chk = 0;
  int n_err = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic exp_t mk(logic [6:0] pins, logic [AW-1:0] a, logic [DW-1:0] d);
    exp_t e;
    {e.ce_n, e.ce, e.we_n, e.oe_n, e.dq_oe, e.ready, e.done} = pins;
    e.addr = a; e.wdata = d; e.chk_rd = 1'b0; e.rdv = '0;
    return e;
  endfunction

  task automatic schedule(bit wr, logic [AW-1:0] a, logic [DW-1:0] d);
    exp_t e;
    if (wr) begin
      shadow[int'(a)] = d;
      for (int i = 0; i < SC; i++) q.push_back(mk(7'b0111100, a, d));
      for (int i = 0; i < WP; i++) q.push_back(mk(7'b0101100, a, d));
      q.push_back(mk(7'b0111100, a, d));
      q.push_back(mk(7'b1011011, a, d));
    end else begin
      for (int i = 0; i < SC; i++) q.push_back(mk(7'b0111000, a, d));
      for (int i = 0; i < RA; i++) q.push_back(mk(7'b0110000, a, d));
      e = mk(7'b1011001, a, d);
      e.chk_rd = 1'b1;
      e.rdv = shadow.exists(int'(a)) ? shadow[int'(a)] : '0;
      q.push_back(e);
      for (int i = 1; i < TT; i++) q.push_back(mk(7'b1011000, a, d));
    end
  endtask

  task automatic add_op(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, int gap);
    op_t o;
    o.wr = wr; o.a = a; o.d = d; o.gap = gap;
    ops.push_back(o);
  endtask

  initial begin
    exp_t e;
    op_t o;
    logic [DW-1:0] last_rd;
    bit have_rd;
    int gap, cyc, idle_run;
    logic [AW-1:0] pool [8];

    pool[0] = 17'h00000; pool[1] = 17'h1FFFF; pool[2] = 17'h00001;
    pool[3] = 17'h10000; pool[4] = 17'h0AAAA; pool[5] = 17'h15555;
    pool[6] = 17'h0F0F0; pool[7] = 17'h1234F;
    for (int i = 0; i < 8; i++) add_op(1'b1, pool[i], DW'(8'h11 * (i + 1)), 0);
    for (int i = 0; i < 8; i++) add_op(1'b0, pool[i], '0, i % 3);
    for (int i = 0; i < 160; i++)
      add_op(bit'($urandom_range(0, 1)), pool[$urandom_range(0, 7)],
             DW'($urandom_range(0, 255)), $urandom_range(0, 2));

    rst = 1'b1; host_req = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 ce_n", 32'(mem_ce_n), 32'd1);
    chk("R1 ce", 32'(mem_ce), 32'd0);
    chk("R1 we_n", 32'(mem_we_n), 32'd1);
    chk("R1 oe_n", 32'(mem_oe_n), 32'd1);
    chk("R1 dq_oe", 32'(mem_dq_oe), 32'd0);
    chk("R1 ready", 32'(host_ready), 32'd1);
    chk("R1 done", 32'(host_done), 32'd0);
    rst = 1'b0;

    have_rd = 1'b0; last_rd = '0; gap = 0; cyc = 0; idle_run = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_err++;
        $display("FAIL watchdog: got %0d cycles expected completion", cyc);
        break;
      end
      e = (q.size() > 0) ? q.pop_front() : mk(7'b1011010, '0, '0);

      chk("R2 select", 32'({mem_ce_n, mem_ce}), 32'({e.ce_n, e.ce}));
      chk("R4 we_n", 32'(mem_we_n), 32'(e.we_n));
      chk("R6 oe_n", 32'(mem_oe_n), 32'(e.oe_n));
      chk("R8 dq_oe", 32'(mem_dq_oe), 32'(e.dq_oe));
      chk("R10 ready", 32'(host_ready), 32'(e.ready));
      chk("R5 R11 done", 32'(host_done), 32'(e.done));
      chk("R9 excl", 32'(!mem_we_n && !mem_oe_n), 32'd0);
      if (!e.ce_n) chk("R3 addr", 32'(mem_addr), 32'(e.addr));
      if (e.dq_oe) chk("R4 wdata", 32'(mem_dq_out), 32'(e.wdata));
      if (e.chk_rd) begin
        last_rd = e.rdv;
        have_rd = 1'b1;
      end
      if (have_rd) chk("R7 rdata", 32'(host_rdata), 32'(last_rd));

      if (e.ready) begin
        if (gap > 0) begin
          host_req = 1'b0;
          gap--;
        end else if (ops.size() > 0) begin
          o = ops.pop_front();
          host_req = 1'b1; host_wr = o.wr; host_addr = o.a; host_wdata = o.d;
          schedule(o.wr, o.a, o.d);
          gap = o.gap;
        end else begin
          host_req = 1'b0;
          if (q.size() == 0) idle_run++;
          if (idle_run > 4) break;
        end
      end else begin
        // R3: requests while busy must be ignored
        host_req   = ($urandom_range(0, 1) == 1);
        host_wr    = ($urandom_range(0, 1) == 1);
        host_addr  = AW'($urandom_range(0, 131071));
        host_wdata = DW'($urandom_range(0, 255));
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule